// File: doc/BRIEF.md
# Locked Watchdog Control Register with Timed Period Change

This block holds the control register of a watchdog that runs in a locked safety configuration. In this configuration the watchdog cannot be switched off. The enable output stays high, and the enable bit always reads back as one. The timeout period is a 3-bit prescaler select. It drives the prescaler that sits outside this block, and it can only be changed through a two-step write sequence that must complete inside a short window.

Software first issues an unlock write with both the change-enable bit and the enable bit set. That write opens a window of `WIN_CYC` cycles, four by default. During the window, the change-enable bit reads as one. The first write in the window that has change-enable cleared loads a new prescaler select from its low bits and closes the window at once. All other writes leave the period unchanged. When the window runs out, change-enable clears by itself.

Top module: `wdc_ctrl`

## Requirements
- R1: After a synchronous reset, the prescaler select is 0, change-enable reads 0, and the read port returns 8'h08.
- R2: `wd_enable` is always 1, and read bit 3 (enable) is always 1, whatever value was written to bit 3.
- R3: Read bits 7:5 always return zero, even after writes that set those bits.
- R4: A write with bit 4 (change-enable) = 1 and bit 3 (enable) = 1 is an unlock. It opens the window, and change-enable reads 1 from the next cycle on. It does not change the prescaler select.
- R5: A write with bit 4 = 0 that falls in any of the four cycles after an unlock loads bits 2:0 into the prescaler select. This holds for both values of bit 3.
- R6: A write with bit 4 = 0 made in the fifth cycle after an unlock, or later, is ignored.
- R7: While the window is open, a write with bit 4 = 1 and bit 3 = 0 is ignored, and the window keeps counting down.
- R8: If no update is accepted, change-enable reads 0 again from the fourth cycle after the unlock.
- R9: An unlock write while the window is open restarts the full four-cycle window.
- R10: An accepted period update closes the window at once, so a further period write without a new unlock is ignored.
- R11: A period write (bit 4 = 0) when no window is open is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_data | input | 8 | Write data: bit 4 change-enable, bit 3 enable, bits 2:0 prescaler select |
| rd_data | output | 8 | Register read value |
| psel | output | 3 | Prescaler select sent to the watchdog prescaler |
| wd_enable | output | 1 | Watchdog enable, held high |

## Verification
The period write is tried in several timing patterns. It is sent with no window open, at the first and the fourth cycle after an unlock, at the fifth cycle after an unlock, and directly after an accepted update. These cases separate a window that is one cycle too short or too long from the correct one, and they show whether an update closes the window. Unlocks repeated while the window is open show whether the window restarts or keeps its old deadline. Writes with change-enable still set but enable clear, and writes with the reserved and enable bits varied, show which bits decide acceptance and which bits are ignored.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
    localparam int DATA_W   = 8;
    localparam int PS_W     = 3;
    localparam int CE_POS   = 4;
    localparam int EN_POS   = 3;
    localparam int WIN_DFLT = 4;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_UNLOCK,
        WR_PERIOD,
        WR_OTHER
    } wr_kind_e;

    typedef struct packed {
        logic [2:0]      rsvd;
        logic            ce;
        logic            en;
        logic [PS_W-1:0] ps;
    } ctrl_reg_t;

    function automatic wr_kind_e classify(input logic we, input ctrl_reg_t d);
        if (!we)
            return WR_NONE;
        if (d.ce && d.en)
            return WR_UNLOCK;
        if (!d.ce)
            return WR_PERIOD;
        return WR_OTHER;
    endfunction

    function automatic ctrl_reg_t compose(input logic ce_now, input logic [PS_W-1:0] ps_now);
        ctrl_reg_t r;
        r.rsvd = '0;
        r.ce   = ce_now;
        r.en   = 1'b1;
        r.ps   = ps_now;
        return r;
    endfunction
endpackage

// File: rtl/wdc_decode.sv
module wdc_decode
    import wdc_pkg::*;
(
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output wr_kind_e          kind,
    output logic [PS_W-1:0]   new_ps
);
    ctrl_reg_t d;

    always_comb begin
        d      = ctrl_reg_t'(wr_data);
        kind   = classify(wr_en, d);
        new_ps = d.ps;
    end
endmodule

// File: rtl/wdc_window.sv
module wdc_window
    import wdc_pkg::*;
#(
    parameter int WIN_CYC = WIN_DFLT
) (
    input  logic     clk,
    input  logic     rst,
    input  wr_kind_e kind,
    output logic     win_open,
    output logic     accept
);
    localparam int CNT_W = $clog2(WIN_CYC + 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        win_open = (cnt_q != '0);
        accept   = win_open && (kind == WR_PERIOD);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (kind == WR_UNLOCK)
            cnt_q <= CNT_W'(WIN_CYC);
        else if (accept)
            cnt_q <= '0;
        else if (win_open)
            cnt_q <= cnt_q - 1'b1;
    end

    // R4
    unlock_opens_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_UNLOCK) |=> (cnt_q == CNT_W'(WIN_CYC)));

    // R10
    accept_closes_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !win_open);

    // R8
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (win_open && kind != WR_UNLOCK && !accept) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R9
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(WIN_CYC));
endmodule

// File: rtl/wdc_period.sv
module wdc_period
    import wdc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic [PS_W-1:0] new_ps,
    output logic [PS_W-1:0] ps_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ps_q <= '0;
        else if (accept)
            ps_q <= new_ps;
    end

    // R6
    period_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(ps_q));

    // R5
    period_load_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (ps_q == $past(new_ps)));
endmodule

// File: rtl/wdc_ctrl.sv
module wdc_ctrl
    import wdc_pkg::*;
#(
    parameter int WIN_CYC = WIN_DFLT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [PS_W-1:0]   psel,
    output logic              wd_enable
);
    wr_kind_e        kind;
    logic [PS_W-1:0] new_ps;
    logic            win_open;
    logic            accept;
    ctrl_reg_t       rd_view;

    wdc_decode u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .kind    (kind),
        .new_ps  (new_ps)
    );

    wdc_window #(.WIN_CYC(WIN_CYC)) u_window (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .win_open (win_open),
        .accept   (accept)
    );

    wdc_period u_period (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .new_ps (new_ps),
        .ps_q   (psel)
    );

    always_comb begin
        rd_view   = compose(win_open, psel);
        rd_data   = DATA_W'(rd_view);
        wd_enable = 1'b1;
    end

    // R11
    closed_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!win_open && wr_en) |=> $stable(psel));

    // R7
    ce_set_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[CE_POS]) |=> $stable(psel));
endmodule

// File: tb/wdc_ctrl_tb_top.sv
module wdc_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [2:0] psel;
    logic       wd_enable;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdc_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .psel      (psel),
        .wd_enable (wd_enable)
    );

    // {wr_en, wr_data, expected rd_data after the edge}
    localparam int NV = 31;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'h08},  // 0  idle, R1
        {1'b1, 8'h05, 8'h08},  // 1  period write, no window: R11
        {1'b1, 8'h18, 8'h18},  // 2  unlock: R4
        {1'b0, 8'h00, 8'h18},  // 3
        {1'b1, 8'h0D, 8'h0D},  // 4  accepted, closes: R5
        {1'b1, 8'h03, 8'h0D},  // 5  no new unlock: R10
        {1'b1, 8'h1F, 8'h1D},  // 6  unlock, ps bits unused: R4
        {1'b0, 8'h00, 8'h1D},  // 7
        {1'b0, 8'h00, 8'h1D},  // 8
        {1'b0, 8'h00, 8'h1D},  // 9
        {1'b1, 8'h02, 8'h0A},  // 10 fourth cycle accepted: R5
        {1'b1, 8'h18, 8'h1A},  // 11 unlock
        {1'b0, 8'h00, 8'h1A},  // 12
        {1'b0, 8'h00, 8'h1A},  // 13
        {1'b0, 8'h00, 8'h1A},  // 14
        {1'b0, 8'h00, 8'h0A},  // 15 self clear: R8
        {1'b1, 8'h07, 8'h0A},  // 16 fifth cycle ignored: R6
        {1'b1, 8'h18, 8'h1A},  // 17 unlock
        {1'b1, 8'h11, 8'h1A},  // 18 ce=1 en=0 ignored: R7
        {1'b1, 8'h04, 8'h0C},  // 19 en=0 still accepted: R5
        {1'b1, 8'h18, 8'h1C},  // 20 unlock
        {1'b0, 8'h00, 8'h1C},  // 21
        {1'b0, 8'h00, 8'h1C},  // 22
        {1'b1, 8'h18, 8'h1C},  // 23 re-unlock restarts: R9
        {1'b0, 8'h00, 8'h1C},  // 24
        {1'b0, 8'h00, 8'h1C},  // 25
        {1'b0, 8'h00, 8'h1C},  // 26
        {1'b1, 8'h01, 8'h09},  // 27 accepted only after restart: R9
        {1'b1, 8'hE6, 8'h09},  // 28 closed: R11, R3
        {1'b1, 8'hF8, 8'h19},  // 29 unlock with reserved bits: R3
        {1'b1, 8'hE6, 8'h0E}   // 30 accepted, upper bits read 0: R3
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] d);
        @(negedge clk);
        wr_en   = we;
        wr_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        rst     = 1'b1;
        wr_en   = 1'b0;
        wr_data = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        check("R1", rd_data, 8'h08);
        check("R1", {5'b0, psel}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][16], VEC[i][15:8]);
            check("R4-R11 table", rd_data, VEC[i][7:0]);
            check("R5", {5'b0, psel}, {5'b0, VEC[i][2:0]});
            check("R2", {7'b0, wd_enable}, 8'h01);
        end

        // reset in the middle of an open window: R1
        step(1'b1, 8'h18);
        check("R4", rd_data, 8'h1E);
        @(negedge clk);
        rst   = 1'b1;
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        check("R1", rd_data, 8'h08);
        check("R1", {5'b0, psel}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        step(1'b1, 8'h03);
        check("R1", rd_data, 8'h08);

        // writing enable bit 0 with change-enable 0 keeps enable high: R2
        step(1'b1, 8'h18);
        step(1'b1, 8'h00);
        check("R2", rd_data, 8'h08);
        check("R2", {7'b0, wd_enable}, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule